// File: doc/BRIEF.md
# Pause-Width Frame Transmitter

This block sends one reader-to-card frame over a single line that rests high. Every bit opens with a fixed low pause. The line then goes back high, and the bit's value is carried by how long the whole bit lasts, counted from the start of its pause. Before a bit is sent, its frame value is combined by XOR with a whitening bit from an external keystream generator. The generator is told to step forward once per bit. The frame is closed by one extra low pause.

One clock cycle is one tick, at 1.5 ticks per microsecond. A host sets the frame word and the bit count, then pulses `start` for one cycle while `busy` is low. The word and the count are latched on that edge. A `done` pulse reports that the frame has ended. The keystream interface has no handshake and no back-pressure. `ks_bit` must hold the current keystream bit whenever a pause is about to open. `ks_adv` pulses once per bit and asks the generator for the next bit, which is needed at least 90 ticks later. `start` is a plain strobe. It is ignored while `busy` is high.

Top module: `pw_frame_tx`

## Requirements
- R1: Out of reset and while idle, `line_out` is 1 and `busy`, `done` and `ks_adv` are 0.
- R2: Call the edge that accepts `start` tick 0. The line stays high until tick 330, and the first bit's pause begins at tick 330.
- R3: Each bit's pause holds `line_out` at 0 for exactly 30 ticks, after which the line returns to 1.
- R4: A transmitted 1 lasts 150 ticks and a transmitted 0 lasts 90 ticks, both counted from the start of its pause. The next pause begins exactly when the previous bit ends.
- R5: Frame bits go out from bit 0 upward. The transmitted bit is frame bit XOR `ks_bit`, sampled in the cycle before the pause opens. `ks_adv` is 1 for exactly the first cycle of each bit's pause and at no other time.
- R6: Right after the last bit, a trailing pause drives the line to 0 for 30 ticks. `busy` is 1 from the cycle after acceptance until that pause ends. `done` is 1 for exactly the one cycle after the trailing pause, and in that cycle `busy` is 0.
- R7: A `start` pulse while `busy` is 1 is ignored. The frame in flight keeps its timing and data, and no new frame begins.
- R8: A length of 0 raises `done` in the cycle after acceptance. It produces no pause, no `ks_adv` pulse and no `busy`.
- R9: A 31-bit frame is sent in full. Its end time is exactly 330 plus the sum of its bit lengths plus 30 ticks, with no drift.
- R10: A `start` given during the `done` cycle is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, 1.5 ticks per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe that starts a frame when idle |
| frame_word | input | 32 | Frame bits, bit 0 is sent first |
| frame_len | input | 5 | Number of bits to send, 0 to 31 |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | One-cycle request to step the keystream |
| line_out | output | 1 | Modulated line, idles high |
| busy | output | 1 | High while a frame is in flight |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
Some properties are checked on every cycle by assertions. Each low pause lasts exactly 30 ticks. The running deadline always lies ahead of the tick count. `done` is a single cycle and never overlaps `busy`. Every keystream advance falls inside a pause. A running frame is never restarted, and a bit is never taken from an empty frame. Other behaviour only the bench's cycle-by-cycle reference can show: the absolute tick at which each pause begins, how the XOR with the keystream turns into bit lengths, the cumulative end time of a full 31-bit frame, the zero-length case, and back-to-back acceptance.

// File: rtl/pw_tx_pkg.sv
package pw_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PAUSE,
    ST_MARK,
    ST_TAIL
  } tx_state_e;
endpackage

// File: rtl/pw_timebase.sv
module pw_timebase #(
  parameter int TW     = 16,
  parameter int LEAD_T = 330
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          add_en,
  input  logic [TW-1:0] add_val,
  output logic          hit
);
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] dl_q;
  logic [TW-1:0] tcnt_nx;

  assign tcnt_nx = tcnt_q + TW'(1);
  assign hit     = run && (tcnt_nx == dl_q);

  // single running deadline: every segment is added to it, never restarted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      dl_q   <= '0;
    end else if (clear) begin
      tcnt_q <= '0;
      dl_q   <= TW'(LEAD_T);
    end else if (run) begin
      tcnt_q <= tcnt_nx;
      if (add_en) dl_q <= dl_q + add_val;
    end
  end

  // R9: the deadline always stays ahead of elapsed ticks
  a_r9_deadline_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dl_q > tcnt_q));
endmodule

// File: rtl/pw_bitsrc.sv
module pw_bitsrc #(
  parameter int FW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [LW-1:0] len_in,
  input  logic          take,
  input  logic          ks_bit,
  output logic          tx_bit,
  output logic          none_left,
  output logic          ks_adv
);
  logic [FW-1:0] sh_q;
  logic [LW-1:0] rem_q;
  logic          tx_q;
  logic          adv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      tx_q  <= 1'b0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= take;
      if (load) begin
        sh_q  <= frame_in;
        rem_q <= len_in;
      end else if (take) begin
        tx_q  <= sh_q[0] ^ ks_bit;
        sh_q  <= {1'b0, sh_q[FW-1:1]};
        rem_q <= rem_q - LW'(1);
      end
    end
  end

  assign tx_bit    = tx_q;
  assign none_left = (rem_q == '0);
  assign ks_adv    = adv_q;

  // R5: a bit is only taken while frame bits remain
  a_r5_take_has_bits: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rem_q != '0));
endmodule

// File: rtl/pw_seq.sv
module pw_seq
  import pw_tx_pkg::*;
#(
  parameter int TW      = 16,
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          len_zero,
  input  logic          hit,
  input  logic          none_left,
  input  logic          tx_bit,
  output logic          clear,
  output logic          run,
  output logic          add_en,
  output logic [TW-1:0] add_val,
  output logic          load,
  output logic          take,
  output logic          line,
  output logic          busy,
  output logic          done
);
  localparam logic [TW-1:0] PAUSE_V = TW'(PAUSE_T);
  localparam logic [TW-1:0] ONE_V   = TW'(ONE_T - PAUSE_T);
  localparam logic [TW-1:0] ZERO_V  = TW'(ZERO_T - PAUSE_T);

  tx_state_e     state_q, state_d;
  logic          line_q, done_q, done_d;
  logic [TW-1:0] lowrun_q;

  always_comb begin
    state_d = state_q;
    clear   = 1'b0;
    load    = 1'b0;
    take    = 1'b0;
    add_val = '0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        clear = 1'b1;
        load  = 1'b1;
        if (len_zero) done_d  = 1'b1;
        else          state_d = ST_LEAD;
      end
      ST_LEAD: if (hit) begin
        state_d = ST_PAUSE;
        take    = 1'b1;
        add_val = PAUSE_V;
      end
      ST_PAUSE: if (hit) begin
        state_d = ST_MARK;
        add_val = tx_bit ? ONE_V : ZERO_V;
      end
      ST_MARK: if (hit) begin
        add_val = PAUSE_V;
        if (none_left) state_d = ST_TAIL;
        else begin
          state_d = ST_PAUSE;
          take    = 1'b1;
        end
      end
      ST_TAIL: if (hit) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      line_q   <= 1'b1;
      done_q   <= 1'b0;
      lowrun_q <= '0;
    end else begin
      state_q  <= state_d;
      line_q   <= !(state_d == ST_PAUSE || state_d == ST_TAIL);
      done_q   <= done_d;
      lowrun_q <= line_q ? '0 : lowrun_q + TW'(1);
    end
  end

  assign run    = (state_q != ST_IDLE);
  assign add_en = hit;
  assign line   = line_q;
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;

  // R3: every low stretch is exactly one pause long
  a_r3_pause_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_q) |-> (lowrun_q == PAUSE_V));
  a_r3_pause_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun_q <= PAUSE_V);
  // R7: a running frame never returns to its lead-in
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q != ST_IDLE && state_q != ST_LEAD) |=> (state_q != ST_LEAD));
endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx #(
  parameter int FW      = 32,
  parameter int LW      = 5,
  parameter int TW      = 16,
  parameter int LEAD_T  = 330,
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame_word,
  input  logic [LW-1:0] frame_len,
  input  logic          ks_bit,
  output logic          ks_adv,
  output logic          line_out,
  output logic          busy,
  output logic          done
);
  logic          clear, run, add_en, load, take, hit, none_left, tx_bit;
  logic [TW-1:0] add_val;

  pw_timebase #(.TW(TW), .LEAD_T(LEAD_T)) u_time (
    .clk(clk), .rst_n(rst_n), .clear(clear), .run(run),
    .add_en(add_en), .add_val(add_val), .hit(hit)
  );

  pw_bitsrc #(.FW(FW), .LW(LW)) u_bits (
    .clk(clk), .rst_n(rst_n), .load(load), .frame_in(frame_word),
    .len_in(frame_len), .take(take), .ks_bit(ks_bit), .tx_bit(tx_bit),
    .none_left(none_left), .ks_adv(ks_adv)
  );

  pw_seq #(.TW(TW), .PAUSE_T(PAUSE_T), .ONE_T(ONE_T), .ZERO_T(ZERO_T)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len_zero(frame_len == '0),
    .hit(hit), .none_left(none_left), .tx_bit(tx_bit), .clear(clear),
    .run(run), .add_en(add_en), .add_val(add_val), .load(load), .take(take),
    .line(line_out), .busy(busy), .done(done)
  );

  // R6: done is a lone pulse outside busy
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5: keystream steps only inside a pause
  a_r5_adv_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |-> (!line_out && busy));
endmodule

// File: tb/tb_pw_frame_tx.sv
module tb_pw_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] frame_word = '0;
  logic [4:0]  frame_len = '0;
  logic        ks_bit;
  logic        ks_adv, line_out, busy, done;

  logic [7:0]  lfsr = 8'h00;
  logic        seed_load = 1'b0;
  logic [7:0]  seed_val = 8'h00;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_word(frame_word),
    .frame_len(frame_len), .ks_bit(ks_bit), .ks_adv(ks_adv),
    .line_out(line_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] lstep(input logic [7:0] l);
    return {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
  endfunction

  // external keystream generator model
  always @(posedge clk) begin
    if (seed_load) lfsr <= seed_val;
    else if (ks_adv) lfsr <= lstep(lfsr);
  end
  assign ks_bit = lfsr[0];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s @%0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  task automatic idle_chk(input int k);
    for (int c = 0; c < k; c++) begin
      @(negedge clk);
      chk("R1", "line", line_out, 1'b1);
      chk("R1", "busy", busy, 1'b0);
      chk("R1", "done", done, 1'b0);
      chk("R1", "ks_adv", ks_adv, 1'b0);
    end
  endtask

  // reference: absolute schedule of pause starts, compared on every cycle
  task automatic run_frame(input logic [31:0] w, input int n, input logic [7:0] seed,
                           input int poke, input string rtag);
    int sch[0:32];
    logic [7:0] l;
    int t, endc;
    string ltag, btag;
    logic low, kexp;
    l = seed;
    t = 330;
    for (int i = 0; i < n; i++) begin
      sch[i] = t;
      t += ((w[i] ^ l[0]) ? 150 : 90);
      l = lstep(l);
    end
    sch[n] = t;
    endc = (n == 0) ? 0 : sch[n] + 30;
    frame_word = w;
    frame_len  = n[4:0];
    seed_val   = seed;
    seed_load  = 1'b1;
    start      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    seed_load = 1'b0;
    frame_word = ~w;
    frame_len = 5'd3;
    for (int c = 0; c <= endc; c++) begin
      if (c > 0) @(negedge clk);
      low = 1'b0;
      kexp = 1'b0;
      ltag = "R4";
      if (n > 0) begin
        for (int i = 0; i <= n; i++)
          if (c >= sch[i] && c < sch[i] + 30) low = 1'b1;
        for (int i = 0; i < n; i++)
          if (c == sch[i]) kexp = 1'b1;
        if (c < sch[0]) ltag = "R2";
        else if (c >= sch[n]) ltag = "R6";
        else if (low) ltag = "R3";
      end else ltag = "R8";
      btag = (n == 0) ? "R8" : "R6";
      chk(ltag, {rtag, " line"}, line_out, !low);
      chk("R5", {rtag, " ks_adv"}, ks_adv, kexp);
      chk(btag, {rtag, " busy"}, busy, (n > 0) && (c < endc));
      chk(btag, {rtag, " done"}, done, c == endc);
      if (c == poke) start = 1'b1;
      if (c == poke + 1) start = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "line in reset", line_out, 1'b1);
    chk("R1", "busy in reset", busy, 1'b0);
    rst_n = 1'b1;
    idle_chk(4);
    run_frame(32'h55, 7, 8'h00, -5, "R2 plain");
    idle_chk(3);
    run_frame(32'h39, 6, 8'hA5, -5, "R5 whitened");
    idle_chk(2);
    run_frame(32'h0, 0, 8'h00, -5, "R8 empty");
    idle_chk(2);
    run_frame(32'h7FFF_FFFF, 31, 8'h00, 1000, "R9 R7 full");
    idle_chk(2);
    run_frame(32'h0000_0ABC, 12, 8'h3C, -5, "R10 first");
    run_frame(32'h0000_0123, 11, 8'h81, 200, "R10 second");
    idle_chk(2);
    run_frame(32'h0, 1, 8'h01, -5, "R5 single");
    idle_chk(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule